// File: doc/BRIEF.md
# EPON Receive 64B/66B Block Decoder

This block sits on the receive path of a dual-lane 25G passive-optical-network physical coding sublayer. It sits behind block alignment and the descrambler. Each accepted 66-bit block is sorted into a class by its sync header, its block type and its 7-bit control codes. The block is then turned back into a 72-bit interface vector of eight control flags and eight octets, ready for the reconciliation sublayer. The class set covers the envelope-specific idle that fills gaps between envelopes and the placeholder that reserves room for FEC parity, besides data, start, terminate and ordinary idle.

A sequence check compares each new block against the class of the vector emitted before it. It uses an envelope-aware table that mirrors the one on the transmit side. A block the table rejects, or that cannot be decoded at all, is replaced by a fixed error vector. Reset produces one link-fault vector first. Both vectors are parameters. Input and output use a valid/ready handshake with one cycle of latency.

The receive state machine has four states. `ST_INIT` presents the link-fault vector and is entered on reset. `ST_NEXT` waits for a block. `ST_VALID` presents a decoded vector. `ST_ERROR` presents the error vector. `ST_INIT`, `ST_VALID` and `ST_ERROR` leave for `ST_NEXT` once their vector is taken. When a new block is accepted in the same cycle, that pass through `ST_NEXT` takes no cycle and the machine goes straight on. From `ST_NEXT`, an accepted block leads to `ST_VALID` when the table allows the pair (previous class, new class) and to `ST_ERROR` when it does not.

Top module: `epon_rx_blk_decoder`

## Requirements
- R1: After reset the block is in `ST_INIT`: `out_valid` is 1, `out_vec` equals `LF_VEC`, and `in_ready` follows `out_ready`. The class remembered for the sequence check is link fault.
- R2: `in_ready` is 1 whenever no vector is held or the held vector is being taken. A block accepted on one clock edge appears on `out_vec` with `out_valid` = 1 after that edge. While `out_valid`=1 and `out_ready`=0, `out_vec` stays unchanged and `in_ready` is 0.
- R3: Bit layout. `in_blk[1:0]` is the sync header and `in_blk[9:2]` the block type. `out_vec[7:0]` holds the flags, with flag bit 7-i belonging to octet i. Octet i is `out_vec[8+8i +: 8]`. A block with sync header 2'b01 decodes to flags 0x00 and octet i = `in_blk[2+8i +: 8]`.
- R4: Type 0x78 (start) decodes to octet 0 = 0xFB and flags 0x80. Octet j (1..7) = `in_blk[10+8(j-1) +: 8]`.
- R5: Terminate types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1, 0xFF place 0xFD at octet k = 0..7 respectively. Octets below k are data taken from `in_blk[10+8j +: 8]`. Octets above k are control codes. Flags are set for octets k..7.
- R6: A control code for octet j sits at `in_blk[10+7j +: 7]` and maps 0x00→0x07, 0x08→0x08, 0x09→0x09, 0x1E→0xFE. A type 0x1E block with all codes 0x00 is idle, all 0x08 is inter-envelope idle, and all 0x09 is parity placeholder. Each of these decodes with flags 0xFF.
- R7: The following are classed "other" and always emitted as the error vector: a sync header of 2'b00 or 2'b11, type 0x2D, 0x33, 0x66, 0x55, 0x4B or any unlisted type, a terminate with an unmapped trailing code, and a type 0x1E block whose codes are not all 0x00, all 0x08 or all 0x09.
- R8: After a link-fault vector, only an inter-envelope idle block is accepted.
- R9: After an inter-envelope idle, only inter-envelope idle, start or parity placeholder is accepted.
- R10: After a terminate or an idle, data and "other" blocks are rejected and everything else is accepted.
- R11: After start, data, parity placeholder or an error vector, every class except "other" is accepted.
- R12: A rejected block emits `ERR_VEC` (by default flags 0xFF and every octet 0xFE), and the remembered class becomes error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A descrambled block is offered |
| in_ready | output | 1 | The block is accepted on this edge |
| in_blk | input | 66 | Descrambled 64B/66B block, sync header in bits 1:0 |
| out_valid | output | 1 | A decoded vector is presented |
| out_ready | input | 1 | Downstream takes the vector on this edge |
| out_vec | output | 72 | Flags in bits 7:0, octet i in bits 8+8i+7:8+8i |

## Verification
The bound checker watches the handshake on every cycle: a stalled vector must hold still and block new input, and an accepted block must produce a vector on the next cycle. It also checks, on every cycle, the outcomes that need no history. A bad sync header or an excluded type must become the error vector. A data or start block must carry its fixed flag pattern unless it was rejected. The sequence table depends on the class remembered from earlier vectors. That part, the octet placement of start and terminate blocks, and the code mapping are shown only by the bench's ordered scenarios, which walk every table row through an explicit expected-vector scoreboard and repeat the link-fault row after a second reset.

// File: rtl/epon_rxdec_pkg.sv
package epon_rxdec_pkg;

    localparam int OCTETS  = 8;
    localparam int OCT_W   = 8;
    localparam int CODE_W  = 7;
    localparam int HDR_W   = 2;
    localparam int BLK_W   = HDR_W + OCTETS * OCT_W;
    localparam int VEC_W   = OCTETS * (OCT_W + 1);
    localparam int PLD_LSB = HDR_W + OCT_W;
    localparam int PLD_W   = BLK_W - PLD_LSB;

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    localparam logic [OCT_W-1:0] BT_CTRL  = 8'h1E;
    localparam logic [OCT_W-1:0] BT_START = 8'h78;

    localparam logic [OCT_W-1:0] SYM_START = 8'hFB;
    localparam logic [OCT_W-1:0] SYM_TERM  = 8'hFD;

    typedef enum logic [3:0] {
        CL_LF, CL_IEI, CL_S, CL_D, CL_T, CL_I, CL_P, CL_E, CL_OTH
    } blk_class_t;

    typedef enum logic [1:0] {
        ST_INIT, ST_NEXT, ST_VALID, ST_ERROR
    } rx_state_t;

    // returns {ok, interface octet}
    function automatic logic [OCT_W:0] map_code(input logic [CODE_W-1:0] c);
        case (c)
            7'h00:   return {1'b1, 8'h07};
            7'h08:   return {1'b1, 8'h08};
            7'h09:   return {1'b1, 8'h09};
            7'h1E:   return {1'b1, 8'hFE};
            default: return {1'b0, 8'h00};
        endcase
    endfunction

    // returns {is_terminate, position of the terminate octet}
    function automatic logic [3:0] term_pos(input logic [OCT_W-1:0] t);
        case (t)
            8'h87:   return 4'b1_000;
            8'h99:   return 4'b1_001;
            8'hAA:   return 4'b1_010;
            8'hB4:   return 4'b1_011;
            8'hCC:   return 4'b1_100;
            8'hD2:   return 4'b1_101;
            8'hE1:   return 4'b1_110;
            8'hFF:   return 4'b1_111;
            default: return 4'b0_000;
        endcase
    endfunction

endpackage

// File: rtl/epon_rxdec_classify.sv
module epon_rxdec_classify
    import epon_rxdec_pkg::*;
(
    input  logic [BLK_W-1:0] blk,
    output blk_class_t       cls,
    output logic [VEC_W-1:0] vec
);

    localparam int EXT_W = OCTETS * OCT_W;

    logic [HDR_W-1:0]         hdr;
    logic [OCT_W-1:0]         btype;
    logic [EXT_W-1:0]         pld_ext;
    logic [OCT_W-1:0]         raw_oct  [OCTETS];
    logic [OCT_W-1:0]         pld_oct  [OCTETS];
    logic [CODE_W-1:0]        code     [OCTETS];
    logic [OCT_W-1:0]         code_map [OCTETS];
    logic [OCTETS-1:0]        code_ok;
    logic [OCTETS-1:0]        is00;
    logic [OCTETS-1:0]        is08;
    logic [OCTETS-1:0]        is09;
    logic [3:0]               tpos;

    assign hdr     = blk[HDR_W-1:0];
    assign btype   = blk[PLD_LSB-1:HDR_W];
    assign pld_ext = {{(EXT_W-PLD_W){1'b0}}, blk[BLK_W-1:PLD_LSB]};
    assign tpos    = term_pos(btype);

    generate
        for (genvar j = 0; j < OCTETS; j++) begin : g_lane
            assign raw_oct[j] = blk[HDR_W + OCT_W*j +: OCT_W];
            assign pld_oct[j] = pld_ext[OCT_W*j +: OCT_W];
            assign code[j]    = blk[PLD_LSB + CODE_W*j +: CODE_W];
            assign {code_ok[j], code_map[j]} = map_code(code[j]);
            assign is00[j] = (code[j] == 7'h00);
            assign is08[j] = (code[j] == 7'h08);
            assign is09[j] = (code[j] == 7'h09);
        end
    endgenerate

    logic [OCTETS-1:0] flg;
    logic [EXT_W-1:0]  dat;
    logic              tail_ok;

    always_comb begin
        cls     = CL_OTH;
        flg     = '0;
        dat     = '0;
        tail_ok = 1'b1;
        case (hdr)
            HDR_DATA: begin
                cls = CL_D;
                for (int j = 0; j < OCTETS; j++) dat[OCT_W*j +: OCT_W] = raw_oct[j];
            end
            HDR_CTRL: begin
                if (btype == BT_CTRL) begin
                    flg = '1;
                    for (int j = 0; j < OCTETS; j++) dat[OCT_W*j +: OCT_W] = code_map[j];
                    if (&is00)      cls = CL_I;
                    else if (&is08) cls = CL_IEI;
                    else if (&is09) cls = CL_P;
                end else if (btype == BT_START) begin
                    cls            = CL_S;
                    flg[OCTETS-1]  = 1'b1;
                    dat[OCT_W-1:0] = SYM_START;
                    for (int j = 1; j < OCTETS; j++) dat[OCT_W*j +: OCT_W] = pld_oct[j-1];
                end else if (tpos[3]) begin
                    for (int j = 0; j < OCTETS; j++) begin
                        if (j < int'(tpos[2:0])) begin
                            dat[OCT_W*j +: OCT_W] = pld_oct[j];
                        end else if (j == int'(tpos[2:0])) begin
                            dat[OCT_W*j +: OCT_W] = SYM_TERM;
                            flg[OCTETS-1-j]       = 1'b1;
                        end else begin
                            dat[OCT_W*j +: OCT_W] = code_map[j];
                            flg[OCTETS-1-j]       = 1'b1;
                            tail_ok               = tail_ok & code_ok[j];
                        end
                    end
                    cls = tail_ok ? CL_T : CL_OTH;
                end
            end
            default: cls = CL_OTH;
        endcase
    end

    assign vec = {dat, flg};

endmodule

// File: rtl/epon_rxdec_seq_table.sv
module epon_rxdec_seq_table
    import epon_rxdec_pkg::*;
(
    input  blk_class_t prev_cls,
    input  blk_class_t next_cls,
    output logic       allowed
);

    always_comb begin
        if (next_cls == CL_OTH || next_cls == CL_LF || next_cls == CL_E) begin
            allowed = 1'b0;
        end else begin
            unique case (prev_cls)
                CL_LF:   allowed = (next_cls == CL_IEI);
                CL_IEI:  allowed = (next_cls == CL_IEI) || (next_cls == CL_S) ||
                                   (next_cls == CL_P);
                CL_T,
                CL_I:    allowed = (next_cls != CL_D);
                default: allowed = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/epon_rx_blk_decoder.sv
module epon_rx_blk_decoder
    import epon_rxdec_pkg::*;
#(
    parameter logic [VEC_W-1:0] LF_VEC  = 72'h01_00_00_9C_01_00_00_9C_88,
    parameter logic [VEC_W-1:0] ERR_VEC = {{OCTETS{8'hFE}}, 8'hFF}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_blk,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_vec
);

    rx_state_t        state, state_nx;
    blk_class_t       prev_cls;
    blk_class_t       new_cls;
    logic [VEC_W-1:0] new_vec;
    logic             seq_ok;
    logic             take;

    epon_rxdec_classify u_cls (
        .blk (in_blk),
        .cls (new_cls),
        .vec (new_vec)
    );

    epon_rxdec_seq_table u_tab (
        .prev_cls (prev_cls),
        .next_cls (new_cls),
        .allowed  (seq_ok)
    );

    assign out_valid = (state != ST_NEXT);
    assign in_ready  = !out_valid || out_ready;
    assign take      = in_valid && in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT, ST_VALID, ST_ERROR: begin
                if (out_ready) begin
                    if (take) state_nx = seq_ok ? ST_VALID : ST_ERROR;
                    else      state_nx = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (take) state_nx = seq_ok ? ST_VALID : ST_ERROR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec  <= LF_VEC;
            prev_cls <= CL_LF;
        end else if (take) begin
            if (seq_ok) begin
                out_vec  <= new_vec;
                prev_cls <= new_cls;
            end else begin
                out_vec  <= ERR_VEC;
                prev_cls <= CL_E;
            end
        end
    end

endmodule

// File: rtl/epon_rx_blk_decoder_chk.sv
module epon_rx_blk_decoder_chk #(
    parameter logic [71:0] ERR_VEC = {{8{8'hFE}}, 8'hFF}
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [9:0]  blk_head,
    input logic        out_valid,
    input logic        out_ready,
    input logic [71:0] out_vec
);

    logic acc;
    assign acc = in_valid && in_ready;

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vec));

    p_backpressure_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    p_bad_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (blk_head[1:0] == 2'b00 || blk_head[1:0] == 2'b11) |=> out_vec == ERR_VEC);

    p_excluded_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && blk_head[1:0] == 2'b10 &&
        (blk_head[9:2] == 8'h2D || blk_head[9:2] == 8'h33 || blk_head[9:2] == 8'h66 ||
         blk_head[9:2] == 8'h55 || blk_head[9:2] == 8'h4B)
        |=> out_vec == ERR_VEC);

    p_data_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && blk_head[1:0] == 2'b01 |=> out_vec[7:0] == 8'h00 || out_vec == ERR_VEC);

    p_start_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && blk_head == {8'h78, 2'b10} |=>
        (out_vec[7:0] == 8'h80 && out_vec[15:8] == 8'hFB) || out_vec == ERR_VEC);

endmodule

bind epon_rx_blk_decoder epon_rx_blk_decoder_chk #(.ERR_VEC(ERR_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .blk_head  (in_blk[9:0]),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vec   (out_vec)
);

// File: tb/epon_rx_blk_decoder_bench.sv
`timescale 1ns/1ps
module epon_rx_blk_decoder_bench;

    localparam logic [71:0] LF  = 72'h01_00_00_9C_01_00_00_9C_88;
    localparam logic [71:0] ERR = {{8{8'hFE}}, 8'hFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [65:0] in_blk = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [71:0] out_vec;

    int n_chk = 0;
    int n_bad = 0;
    logic [71:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    epon_rx_blk_decoder u_epon_rx_blk_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_blk(in_blk), .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec)
    );

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: a transfer happens at the posedge after a negedge with valid&ready
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("unexpected output", out_vec, '0);
                end else begin
                    check(tag_q.pop_front(), out_vec, exp_q.pop_front());
                end
            end
        end
    end

    function automatic logic [71:0] mkvec(input logic [7:0] f, input logic [63:0] o);
        return {o, f};
    endfunction
    function automatic logic [65:0] cblk(input logic [7:0] t, input logic [55:0] p);
        return {p, t, 2'b10};
    endfunction

    task automatic send(input logic [65:0] b, input logic [71:0] e, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_blk   = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic do_reset(input string tag);
        @(posedge clk); #1;
        rst_n = 1'b0;
        exp_q.push_back(LF);
        tag_q.push_back(tag);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    localparam logic [63:0] D1 = 64'h8877_6655_4433_2211;
    localparam logic [63:0] D2 = 64'h0123_4567_89AB_CDEF;
    localparam logic [55:0] S1 = 56'hA6A5_A4A3_A2A1_A0;

    logic [65:0] b_iei, b_p, b_i, b_s, b_d1, b_d2, b_t3, b_t3bad, b_t7, b_t0, b_mix;
    logic [71:0] v_iei, v_p, v_i, v_s, v_d1, v_d2, v_t3, v_t7, v_t0;

    initial begin
        b_iei = cblk(8'h1E, {8{7'h08}}); v_iei = mkvec(8'hFF, {8{8'h08}});
        b_p   = cblk(8'h1E, {8{7'h09}}); v_p   = mkvec(8'hFF, {8{8'h09}});
        b_i   = cblk(8'h1E, {8{7'h00}}); v_i   = mkvec(8'hFF, {8{8'h07}});
        b_s   = cblk(8'h78, S1);         v_s   = mkvec(8'h80, {S1, 8'hFB});
        b_d1  = {D1, 2'b01};             v_d1  = mkvec(8'h00, D1);
        b_d2  = {D2, 2'b01};             v_d2  = mkvec(8'h00, D2);
        // terminate at octet 3, code 0x1E in octet 5
        b_t3    = cblk(8'hB4, {7'h00, 7'h00, 7'h1E, 7'h00, 4'h0, 24'hCCBBAA});
        v_t3    = mkvec(8'h1F, {8'h07, 8'h07, 8'hFE, 8'h07, 8'hFD, 24'hCCBBAA});
        b_t3bad = cblk(8'hB4, {7'h00, 7'h00, 7'h00, 7'h55, 4'h0, 24'hCCBBAA});
        b_t7  = cblk(8'hFF, S1);         v_t7  = mkvec(8'h01, {8'hFD, S1});
        b_t0  = cblk(8'h87, {{7{7'h00}}, 7'h00}); v_t0 = mkvec(8'hFF, {{7{8'h07}}, 8'hFD});
        b_mix = cblk(8'h1E, {{4{7'h08}}, {4{7'h00}}});

        do_reset("R1 link-fault after reset");
        @(negedge clk);
        n_chk++;
        if (!(out_valid === 1'b1 && in_ready === out_ready)) begin
            n_bad++;
            $display("FAIL R1 actual valid=%b ready=%b expected valid=1 ready=%b",
                     out_valid, in_ready, out_ready);
        end

        send(b_s,   ERR,   "R8 start after link fault rejected");
        send(b_iei, v_iei, "R11 IEI after error");
        send(b_d1,  ERR,   "R9 data after IEI rejected");
        send(b_iei, v_iei, "R11 IEI after error (2)");
        send(b_p,   v_p,   "R9 parity placeholder after IEI");
        send(b_d1,  v_d1,  "R11 data after parity");
        send(b_s,   v_s,   "R4 start decode after data");
        send(b_d2,  v_d2,  "R3 data decode after start");
        send(b_t3,  v_t3,  "R5 R6 terminate octet3 with error code");
        send(b_d1,  ERR,   "R10 data after terminate rejected");
        send(b_i,   v_i,   "R6 idle decode after error");
        send(b_t7,  v_t7,  "R5 terminate octet7 after idle");
        send(b_t0,  v_t0,  "R5 terminate octet0 after terminate");
        send(b_i,   v_i,   "R10 idle after terminate");
        send(b_d2,  ERR,   "R10 data after idle rejected");
        send({D1, 2'b11}, ERR, "R7 sync header 11");
        send({D1, 2'b00}, ERR, "R7 sync header 00");
        send(cblk(8'h2D, S1), ERR, "R7 excluded type 0x2D");
        send(cblk(8'h4B, S1), ERR, "R7 excluded type 0x4B");
        send(b_t3bad, ERR, "R7 terminate with unmapped code");
        send(b_iei, v_iei, "R11 IEI after error (3)");
        send(b_iei, v_iei, "R9 IEI after IEI");
        send(b_s,   v_s,   "R9 start after IEI");
        send(b_mix, ERR,   "R7 R11 mixed control codes rejected after start");
        send(b_d1,  v_d1,  "R12 data after error vector");
        drain();

        // R2 stall: block accepted while output is being held back
        @(posedge clk); #1;
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_blk    = b_d2;
        @(posedge clk); #1;
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            n_chk++;
            if (!(out_valid === 1'b1 && in_ready === 1'b0 && out_vec === v_d2)) begin
                n_bad++;
                $display("FAIL R2 actual valid=%b ready=%b vec=%h expected valid=1 ready=0 vec=%h",
                         out_valid, in_ready, out_vec, v_d2);
            end
        end
        @(posedge clk); #1;
        exp_q.push_back(v_d2);
        tag_q.push_back("R2 held vector released");
        out_ready = 1'b1;
        drain();
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 actual valid=%b expected valid=0", out_valid);
        end

        do_reset("R1 link-fault after second reset");
        send(b_d1,  ERR,   "R8 data after link fault rejected");
        do_reset("R1 link-fault after third reset");
        send(b_iei, v_iei, "R8 IEI after link fault accepted");
        send(cblk(8'h55, S1), ERR, "R12 error vector content");
        drain();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule